// File: doc/BRIEF.md
# Fetch Group Collapser

This block sits between instruction fetch and rename. Each fetch pair carries two groups of eight instructions. The first group (A) is always the line at the fetch address. The second group (B) is either the next sequential line or a line fetched from a predicted branch target. Each group comes with a per-slot mask of predicted-taken branches. A pair is first stored in a one-entry slot for its hardware thread. Later, a read request names a thread, and the stored pair is reduced to the instructions on the predicted path.

The reduction honours up to two predicted branches: one in A and one in B. It discards the slots the path skips. The survivors are packed in path order into an eight-slot output with a contiguous valid mask. When more than eight instructions survive, the output carries the first eight, and a count tells fetch how many were left behind for refetch.

Top module: `fetch_collapser`

## Requirements
- R1: While reset is asserted (synchronous, active low), `out_valid` is 0 on the next clock and every bit of `buf_full` is 0.
- R2: A cycle with `in_valid` high stores the pair in the entry of thread `in_tid` and sets `buf_full[in_tid]` from the next cycle. Writing to an occupied entry replaces its contents.
- R3: A read (`rd_en`) of a full entry raises `out_valid` for one cycle on the next clock, with `out_tid` equal to `rd_tid`, and clears that entry unless the same cycle also writes it. A read of an empty entry produces no output.
- R4: In group A, every slot up to and including the lowest slot whose `in_a_taken` bit is 1 survives. All later A slots are dropped.
- R5: With `in_b_target`=1, group B is used only when A holds a predicted-taken branch. B slots below `in_b_entry` are then dropped.
- R6: With `in_b_target`=0, group B is used from slot 0, but only when A holds no predicted-taken branch. If the line type does not match A's branch state, all of group B is dropped.
- R7: Within the used part of B, slots after the lowest predicted-taken branch at or above the start slot are dropped. The branch slot itself survives. Taken bits below the entry point have no effect.
- R8: Survivors appear in path order: A in ascending slot order, then B in ascending slot order. They are packed from output slot 0. `out_mask` bit j is 1 exactly for the occupied slots j, and unused slots read as zero.
- R9: When more than eight instructions survive, the first eight in path order are emitted, `out_mask` is all ones, and `out_left` equals the survivor count minus eight. Otherwise `out_left` is 0.
- R10: Entries of different threads are independent. Writing or reading one thread leaves the stored pair of every other thread unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Store the presented fetch pair |
| in_tid | input | 2 | Thread that owns the presented pair |
| in_grp_a | input | 256 | Group A, slot i at bits [32i+31:32i] |
| in_grp_b | input | 256 | Group B, same slot layout |
| in_a_taken | input | 8 | Predicted-taken branch mask for group A, bit i = slot i |
| in_b_taken | input | 8 | Predicted-taken branch mask for group B, bit i = slot i |
| in_b_target | input | 1 | 1: B is a branch-target line, 0: B is sequential |
| in_b_entry | input | 3 | Entry slot of B when it is a target line |
| rd_en | input | 1 | Collapse and release the entry of `rd_tid` |
| rd_tid | input | 2 | Thread to read |
| buf_full | output | 4 | Occupancy of each thread entry |
| out_valid | output | 1 | Output group valid (one cycle per read) |
| out_tid | output | 2 | Thread of the output group |
| out_insn | output | 256 | Packed path-ordered instructions, slot j at bits [32j+31:32j] |
| out_mask | output | 8 | Occupied output slots |
| out_left | output | 4 | Survivors not emitted, to be refetched |

## Verification
A wrong occupancy bit appears at the ports within one cycle, either as a phantom or missing `out_valid` pulse after a read or as a stale `buf_full` bit. A wrong survivor decision or a wrong packing offset appears in `out_insn` and `out_mask` on the cycle after the read. Each instruction word encodes its group, thread, load generation and slot, so a misplaced, dropped or stale word is identified by value. An overflow miscount shows as an `out_left` that disagrees with the number of survivors beyond eight.

// File: rtl/collapse_pkg.sv
// collapse_pkg: shared definitions for the fetch group collapser.
// Assumes: nothing beyond IEEE 1800-2017.
package collapse_pkg;

    // How the second fetch group joins the predicted path.
    typedef enum logic [1:0] {
        ROUTE_NONE = 2'd0,   // line type disagrees with group A's branch state
        ROUTE_SEQ  = 2'd1,   // sequential line, entered at slot 0
        ROUTE_TGT  = 2'd2    // branch target line, entered at the entry offset
    } b_route_e;

endpackage

// File: rtl/collapse_thread_buffer.sv
// collapse_thread_buffer: one entry per hardware thread, holding one fetch pair.
// A write sets the thread's full bit and replaces any older contents. A read
// clears the bit unless the same thread is written in the same cycle (the write wins).
// Assumes: the read data path is combinational. The storage is not reset, only the full bits are.
module collapse_thread_buffer #(
    parameter int unsigned THREADS = 4,
    parameter int unsigned EW      = 8,
    localparam int unsigned TW     = $clog2(THREADS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [TW-1:0]      wr_tid,
    input  logic [EW-1:0]      wr_data,
    input  logic               rd_en,
    input  logic [TW-1:0]      rd_tid,
    output logic [EW-1:0]      rd_data,
    output logic               rd_hit,
    output logic [THREADS-1:0] full
);

    logic [EW-1:0] store [THREADS];

    for (genvar t = 0; t < THREADS; t++) begin : g_thread
        // Capture a new pair for this thread.
        always_ff @(posedge clk) begin
            if (wr_en && wr_tid == TW'(t)) begin
                store[t] <= wr_data;
            end
        end

        // Track occupancy: the write wins over a release in the same cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                full[t] <= 1'b0;
            end else if (wr_en && wr_tid == TW'(t)) begin
                full[t] <= 1'b1;
            end else if (rd_en && rd_tid == TW'(t)) begin
                full[t] <= 1'b0;
            end
        end
    end

    // Present the selected entry and whether the read finds data.
    always_comb begin
        rd_data = store[rd_tid];
        rd_hit  = rd_en && full[rd_tid];
    end

endmodule

// File: rtl/collapse_survivor_mask.sv
// collapse_survivor_mask: decides which of the 2*SLOTS candidates lie on the
// predicted path. Group A survives up to and including its first taken branch.
// Group B joins only when its line type matches A's branch state. B starts at
// the entry slot (target) or slot 0 (sequential) and ends at its first taken
// branch at or above that start.
// Assumes: purely combinational. keep bit i covers A slot i, bit SLOTS+i covers B slot i.
module collapse_survivor_mask
    import collapse_pkg::*;
#(
    parameter int unsigned SLOTS = 8,
    localparam int unsigned OW   = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0]   a_taken,
    input  logic [SLOTS-1:0]   b_taken,
    input  logic               b_target,
    input  logic [OW-1:0]      b_entry,
    output logic [2*SLOTS-1:0] keep
);

    b_route_e route;
    logic     a_hit;
    logic     b_stop;
    logic     in_range;

    // Walk both groups in path order and mark the survivors.
    always_comb begin
        keep   = '0;
        a_hit  = 1'b0;
        b_stop = 1'b0;
        for (int unsigned i = 0; i < SLOTS; i++) begin
            keep[i] = !a_hit;
            if (a_taken[i]) a_hit = 1'b1;
        end
        if (a_hit && b_target)        route = ROUTE_TGT;
        else if (!a_hit && !b_target) route = ROUTE_SEQ;
        else                          route = ROUTE_NONE;
        for (int unsigned i = 0; i < SLOTS; i++) begin
            in_range = (route == ROUTE_SEQ) ||
                       (route == ROUTE_TGT && i >= 32'(b_entry));
            keep[SLOTS+i] = in_range && !b_stop;
            if (in_range && b_taken[i]) b_stop = 1'b1;
        end
    end

endmodule

// File: rtl/collapse_compactor.sv
// collapse_compactor: packs the kept candidates, in index order, into the low
// output slots. It builds a contiguous valid mask and reports survivors beyond the output width.
// Assumes: purely combinational. Candidate i is at bits [IW*i +: IW].
module collapse_compactor #(
    parameter int unsigned SLOTS = 8,
    parameter int unsigned IW    = 32,
    localparam int unsigned NC   = 2 * SLOTS,
    localparam int unsigned LW   = $clog2(SLOTS + 1)
) (
    input  logic [NC*IW-1:0]    cand,
    input  logic [NC-1:0]       keep,
    output logic [SLOTS*IW-1:0] packed_insn,
    output logic [SLOTS-1:0]    packed_mask,
    output logic [LW-1:0]       left
);

    int unsigned pos;

    // Place each survivor at the slot given by the survivors ahead of it.
    always_comb begin
        packed_insn = '0;
        pos         = 0;
        for (int unsigned i = 0; i < NC; i++) begin
            if (keep[i]) begin
                if (pos < SLOTS) packed_insn[pos*IW +: IW] = cand[i*IW +: IW];
                pos = pos + 1;
            end
        end
    end

    // Derive the occupancy mask and the overflow count from the total.
    always_comb begin
        for (int unsigned j = 0; j < SLOTS; j++) packed_mask[j] = (j < pos);
        left = (pos > SLOTS) ? LW'(pos - SLOTS) : '0;
    end

endmodule

// File: rtl/fetch_collapser.sv
// fetch_collapser: per-thread buffered merge of two fetch groups into one
// path-ordered group. Pairs are stored per thread. A read collapses the stored
// pair and registers the result, so it appears on the cycle after the read.
// Assumes: synchronous active-low reset. out_valid pulses once per successful read.
module fetch_collapser #(
    parameter int unsigned IW      = 32,
    parameter int unsigned SLOTS   = 8,
    parameter int unsigned THREADS = 4,
    localparam int unsigned OW     = $clog2(SLOTS),
    localparam int unsigned TW     = $clog2(THREADS),
    localparam int unsigned LW     = $clog2(SLOTS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [TW-1:0]       in_tid,
    input  logic [SLOTS*IW-1:0] in_grp_a,
    input  logic [SLOTS*IW-1:0] in_grp_b,
    input  logic [SLOTS-1:0]    in_a_taken,
    input  logic [SLOTS-1:0]    in_b_taken,
    input  logic                in_b_target,
    input  logic [OW-1:0]       in_b_entry,
    input  logic                rd_en,
    input  logic [TW-1:0]       rd_tid,
    output logic [THREADS-1:0]  buf_full,
    output logic                out_valid,
    output logic [TW-1:0]       out_tid,
    output logic [SLOTS*IW-1:0] out_insn,
    output logic [SLOTS-1:0]    out_mask,
    output logic [LW-1:0]       out_left
);

    localparam int unsigned GW = SLOTS * IW;
    localparam int unsigned EW = 2 * GW + 2 * SLOTS + 1 + OW;

    logic [EW-1:0]      wr_entry;
    logic [EW-1:0]      rd_entry;
    logic               rd_hit;
    logic [GW-1:0]      st_a;
    logic [GW-1:0]      st_b;
    logic [SLOTS-1:0]   st_a_taken;
    logic [SLOTS-1:0]   st_b_taken;
    logic               st_b_target;
    logic [OW-1:0]      st_b_entry;
    logic [2*SLOTS-1:0] keep;
    logic [GW-1:0]      nxt_insn;
    logic [SLOTS-1:0]   nxt_mask;
    logic [LW-1:0]      nxt_left;

    // Pack the incoming pair and its prediction fields into one buffer word.
    always_comb begin
        wr_entry = {in_b_entry, in_b_target, in_b_taken, in_a_taken, in_grp_b, in_grp_a};
    end

    // Unpack the selected buffer word.
    always_comb begin
        {st_b_entry, st_b_target, st_b_taken, st_a_taken, st_b, st_a} = rd_entry;
    end

    collapse_thread_buffer #(.THREADS(THREADS), .EW(EW)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (in_valid),
        .wr_tid  (in_tid),
        .wr_data (wr_entry),
        .rd_en   (rd_en),
        .rd_tid  (rd_tid),
        .rd_data (rd_entry),
        .rd_hit  (rd_hit),
        .full    (buf_full)
    );

    collapse_survivor_mask #(.SLOTS(SLOTS)) u_mask (
        .a_taken  (st_a_taken),
        .b_taken  (st_b_taken),
        .b_target (st_b_target),
        .b_entry  (st_b_entry),
        .keep     (keep)
    );

    collapse_compactor #(.SLOTS(SLOTS), .IW(IW)) u_pack (
        .cand        ({st_b, st_a}),
        .keep        (keep),
        .packed_insn (nxt_insn),
        .packed_mask (nxt_mask),
        .left        (nxt_left)
    );

    // Register the collapsed group. Data is updated only on a successful read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_tid   <= '0;
            out_insn  <= '0;
            out_mask  <= '0;
            out_left  <= '0;
        end else begin
            out_valid <= rd_hit;
            if (rd_hit) begin
                out_tid  <= rd_tid;
                out_insn <= nxt_insn;
                out_mask <= nxt_mask;
                out_left <= nxt_left;
            end
        end
    end

endmodule

// File: rtl/fetch_collapser_chk.sv
// fetch_collapser_chk: temporal checks on the collapser's ports, bound into every instance.
// Assumes: same parameters as the bound instance.
module fetch_collapser_chk #(
    parameter int unsigned SLOTS   = 8,
    parameter int unsigned THREADS = 4,
    localparam int unsigned TW     = $clog2(THREADS),
    localparam int unsigned LW     = $clog2(SLOTS + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [TW-1:0]      in_tid,
    input logic               rd_en,
    input logic [TW-1:0]      rd_tid,
    input logic [THREADS-1:0] buf_full,
    input logic               out_valid,
    input logic [TW-1:0]      out_tid,
    input logic [SLOTS-1:0]   out_mask,
    input logic [LW-1:0]      out_left
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && buf_full == '0));

    assert_write_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> buf_full[$past(in_tid)]);

    assert_read_emits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && buf_full[rd_tid]) |=> (out_valid && out_tid == $past(rd_tid)));

    assert_no_phantom_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && buf_full[rd_tid]) |=> !out_valid);

    assert_read_releases_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !(in_valid && in_tid == rd_tid)) |=> !buf_full[$past(rd_tid)]);

    assert_mask_packed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_mask & (out_mask + 1'b1)) == '0));

    assert_overflow_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_left != '0) |-> (&out_mask));

endmodule

bind fetch_collapser fetch_collapser_chk #(.SLOTS(SLOTS), .THREADS(THREADS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_tid    (in_tid),
    .rd_en     (rd_en),
    .rd_tid    (rd_tid),
    .buf_full  (buf_full),
    .out_valid (out_valid),
    .out_tid   (out_tid),
    .out_mask  (out_mask),
    .out_left  (out_left)
);

// File: tb/tb_fetch_collapser.sv
// tb_fetch_collapser: directed scenarios, each task checks its own results.
module tb_fetch_collapser;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   in_tid = '0;
    logic [255:0] in_grp_a = '0;
    logic [255:0] in_grp_b = '0;
    logic [7:0]   in_a_taken = '0;
    logic [7:0]   in_b_taken = '0;
    logic         in_b_target = 1'b0;
    logic [2:0]   in_b_entry = '0;
    logic         rd_en = 1'b0;
    logic [1:0]   rd_tid = '0;
    logic [3:0]   buf_full;
    logic         out_valid;
    logic [1:0]   out_tid;
    logic [255:0] out_insn;
    logic [7:0]   out_mask;
    logic [3:0]   out_left;

    int n_checks = 0;
    int n_fail   = 0;

    // What the bench last loaded for each thread.
    logic [7:0] sh_at [4];
    logic [7:0] sh_bt [4];
    logic       sh_tg [4];
    logic [2:0] sh_en [4];
    int         sh_gen [4];

    always #4 clk = ~clk;

    fetch_collapser dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tid(in_tid),
        .in_grp_a(in_grp_a), .in_grp_b(in_grp_b), .in_a_taken(in_a_taken),
        .in_b_taken(in_b_taken), .in_b_target(in_b_target), .in_b_entry(in_b_entry),
        .rd_en(rd_en), .rd_tid(rd_tid), .buf_full(buf_full), .out_valid(out_valid),
        .out_tid(out_tid), .out_insn(out_insn), .out_mask(out_mask), .out_left(out_left)
    );

    function automatic logic [31:0] mk(bit isb, int tid, int gen, int i);
        return {(isb ? 4'hB : 4'hA), 4'(tid), 8'(gen), 16'(i)};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [255:0] act, logic [255:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic load(int tid, int gen, logic [7:0] at, logic [7:0] bt, bit tg, int ent);
        @(negedge clk);
        in_valid = 1'b1;
        in_tid = 2'(tid);
        for (int i = 0; i < 8; i++) begin
            in_grp_a[i*32 +: 32] = mk(0, tid, gen, i);
            in_grp_b[i*32 +: 32] = mk(1, tid, gen, i);
        end
        in_a_taken = at; in_b_taken = bt; in_b_target = tg; in_b_entry = 3'(ent);
        sh_at[tid] = at; sh_bt[tid] = bt; sh_tg[tid] = tg; sh_en[tid] = 3'(ent); sh_gen[tid] = gen;
        @(negedge clk);
        in_valid = 1'b0;
        chk(buf_full[tid] == 1'b1, "R2", "entry full after write", 256'(buf_full), 256'(4'(1 << tid)));
    endtask

    // Read a thread and compare the result with the path the requirements define.
    task automatic drain(int tid, string req);
        logic [255:0] e_insn;
        int           total;
        bit           a_hit;
        bit           use_b;
        bit           stop;
        int           st;
        logic [7:0]   e_mask;
        e_insn = '0; total = 0; a_hit = 0; stop = 0;
        for (int i = 0; i < 8; i++) begin
            if (!a_hit) begin
                if (total < 8) e_insn[total*32 +: 32] = mk(0, tid, sh_gen[tid], i);
                total++;
            end
            if (sh_at[tid][i]) a_hit = 1;
        end
        use_b = a_hit ? sh_tg[tid] : !sh_tg[tid];
        st = sh_tg[tid] ? int'(sh_en[tid]) : 0;
        for (int i = st; i < 8; i++) begin
            if (use_b && !stop) begin
                if (total < 8) e_insn[total*32 +: 32] = mk(1, tid, sh_gen[tid], i);
                total++;
            end
            if (sh_bt[tid][i]) stop = 1;
        end
        e_mask = '0;
        for (int j = 0; j < 8; j++) e_mask[j] = (j < total);
        @(negedge clk);
        rd_en = 1'b1; rd_tid = 2'(tid);
        @(negedge clk);
        rd_en = 1'b0;
        chk(out_valid == 1'b1, "R3", "out_valid after read", 256'(out_valid), 256'(1));
        chk(out_tid == 2'(tid), "R3", "out_tid", 256'(out_tid), 256'(tid));
        chk(out_insn == e_insn, req, "out_insn", out_insn, e_insn);
        chk(out_mask == e_mask, "R8", "out_mask", 256'(out_mask), 256'(e_mask));
        chk(out_left == 4'(total > 8 ? total - 8 : 0), "R9", "out_left",
            256'(out_left), 256'(total > 8 ? total - 8 : 0));
        chk(buf_full[tid] == 1'b0, "R3", "entry released", 256'(buf_full), 256'(0));
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(out_valid == 1'b0, "R1", "out_valid in reset", 256'(out_valid), 256'(0));
        chk(buf_full == 4'h0, "R1", "buf_full in reset", 256'(buf_full), 256'(0));
    endtask

    task automatic t_sequential_overflow();   // R6 R9: 16 survivors
        load(0, 1, 8'h00, 8'h00, 1'b0, 0);
        drain(0, "R9");
    endtask

    task automatic t_target_entry();          // R4 R5: A0..A2, B5..B7
        load(1, 2, 8'h04, 8'h00, 1'b1, 5);
        drain(1, "R5");
    endtask

    task automatic t_two_branches();          // R7: A0..A3, B1..B4
        load(2, 3, 8'h08, 8'h10, 1'b1, 1);
        drain(2, "R7");
    endtask

    task automatic t_line_mismatch();         // R6: taken in A but B sequential
        load(3, 4, 8'h20, 8'h00, 1'b0, 0);
        drain(3, "R6");
        load(3, 5, 8'h00, 8'h00, 1'b1, 2);    // R5: no taken in A, B is target
        drain(3, "R5");
    endtask

    task automatic t_taken_below_entry();     // R7: bit 2 ignored, stop at 6
        load(0, 6, 8'h01, 8'h44, 1'b1, 4);
        drain(0, "R7");
        load(0, 7, 8'h90, 8'h00, 1'b0, 0);    // R4: first taken at slot 4
        drain(0, "R4");
    endtask

    task automatic t_read_empty();            // R3: empty thread gives no output
        @(negedge clk);
        rd_en = 1'b1; rd_tid = 2'd2;
        @(negedge clk);
        rd_en = 1'b0;
        chk(out_valid == 1'b0, "R3", "no output on empty read", 256'(out_valid), 256'(0));
    endtask

    task automatic t_threads();               // R2 R10: replace and isolate
        load(1, 8, 8'h02, 8'h00, 1'b1, 0);
        load(2, 9, 8'h00, 8'h00, 1'b0, 0);
        load(1, 10, 8'h00, 8'h01, 1'b1, 3);
        chk(buf_full == 4'b0110, "R10", "two threads held", 256'(buf_full), 256'(4'b0110));
        drain(1, "R2");
        chk(buf_full[2] == 1'b1, "R10", "other thread kept", 256'(buf_full), 256'(4'b0100));
        drain(2, "R10");
    endtask

    initial begin
        t_reset();
        t_sequential_overflow();
        t_target_entry();
        t_two_branches();
        t_line_mismatch();
        t_taken_below_entry();
        t_read_empty();
        t_threads();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule